// File: doc/BRIEF.md
# Skewed-Strobe Delay Test Sequencer

This block lets a slow tester check the timing of a fast device. It runs from a single fast reference clock, where one reference cycle is one rated period of the device. A test period is N rated periods long, with N between 1 and 16. In each test period the block presents one new vector index, gives the device flip-flops a clock enable on every rated cycle, and drives a slow test clock. It raises one output strobe at a programmable offset of k rated periods after the start of the period. At that strobe it compares the device response against an expected word held in an internal table.

One run is N passes over the whole vector set. The strobe offset is k = 1 in the first pass and rises by one in each later pass, up to k = N. A run therefore lasts N·N·NVEC rated cycles. The expected table holds its own entry for each pair of vector and pass, because the device state keeps moving under the rated clock between strobes. Mismatches are counted and flagged as they happen, together with the pass number. The first failing vector and pass are latched. A one-cycle done pulse marks the end of the run.

The controller has three states. S_IDLE moves to S_RUN when start is seen. S_RUN stays in S_RUN until the last rated cycle of the last vector of pass N, then moves to S_DONE. S_DONE always moves back to S_IDLE after one cycle. The only other register updates are the per-period vector/pass step inside S_RUN and the clear that happens when start is taken.

Top module: `dts_sequencer`

## Requirements
- R1: After reset, busy, done, fail, strobe, vec_adv, rated_en, test_clk and mis_hit are 0 and err_cnt is 0.
- R2: In S_IDLE, start begins a run with N = n_sel + 1, meaning n_sel holds N−1. The run starts at vector 0 of pass 1 and clears fail, fail_vec, fail_k and err_cnt.
- R3: While running, every test period is exactly N reference cycles with rated_en high in each of them, and busy stays high for exactly N·N·NVEC cycles.
- R4: vec_adv is high in the first cycle of each test period. vec_idx steps through 0 to NVEC−1 within a pass and returns to 0 when pass_k steps.
- R5: test_clk is high for the first ceil(N/2) cycles of each test period and low for the rest.
- R6: strobe is high exactly once per test period, k−1 cycles after the vec_adv cycle of that period. With k = 1 it shares the vec_adv cycle.
- R7: Passes run in the order pass_k = 1, 2, …, N, and each pass covers the whole vector set.
- R8: Table entries are written on a clock edge where exp_we is high. The address is formed as bits [AW−1:VW] = k−1 and bits [VW−1:0] = vector index.
- R9: mis_hit is high in a strobe cycle exactly when dut_resp differs from the table entry for the current vector and pass.
- R10: err_cnt holds the number of mismatching strobes in the current run, and it never decreases during a run.
- R11: fail is sticky for the rest of the run. fail_vec and fail_k hold the vector and pass of the first mismatch.
- R12: done is a one-cycle pulse in the cycle after the final strobe, with busy low. A mismatch on the final strobe is already visible in fail, fail_k and err_cnt in that cycle.
- R13: start is ignored while a run is in progress. N, the pass order and the run length are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, one rated period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only in S_IDLE) |
| n_sel | input | 4 | Speed-reduction factor minus one |
| exp_we | input | 1 | Expected-table write enable |
| exp_addr | input | AW (7) | Table address {k−1, vector} |
| exp_wdata | input | W (8) | Expected response word |
| dut_resp | input | W (8) | Device outputs to be sampled |
| test_clk | output | 1 | Slow test clock |
| rated_en | output | 1 | Rated-speed clock enable for device flip-flops |
| vec_adv | output | 1 | Pulse: apply next input vector |
| strobe | output | 1 | Output sampling strobe |
| vec_idx | output | VW (3) | Current vector index |
| pass_k | output | 5 | Current pass / strobe offset k |
| mis_hit | output | 1 | Mismatch at this strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky fail flag |
| fail_vec | output | VW (3) | Vector index of first mismatch |
| fail_k | output | 5 | Pass of first mismatch |
| err_cnt | output | 8 | Mismatch count (saturating) |

## Verification
In pass 1 the sampling strobe lands in the same cycle as the vector-advance pulse, because k = 1 means the strobe sits in slot 0 of the period. With N = 1 this happens on every cycle of the run. The bench provokes this collision by running with N = 1 and with larger N. A cycle counter restarts on each vec_adv and is read on each strobe. The scoreboard expects a gap of k−1 and checks that the vector index popped is the one advanced in that same cycle. A second collision is a mismatch on the very last strobe together with the move to S_DONE. The bench injects a fault at vector NVEC−1 of pass N, then checks that fail, fail_k and err_cnt already show it in the done cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dts_phase_gen.sv
// Slot counter within one test period plus the slow test clock.
module dts_phase_gen #(
    parameter int SW = 4,
    localparam int KW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [KW-1:0] n_len,
    output logic [SW-1:0] slot,
    output logic          wrap,
    output logic          tclk
);
    logic [SW-1:0] slot_q;

    assign wrap = run && ({1'b0, slot_q} == n_len - KW'(1));
    // high while 2*slot < N, i.e. the first ceil(N/2) slots
    assign tclk = run && ({1'b0, slot_q, 1'b0} < {1'b0, n_len});
    assign slot = slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (clr) begin
            slot_q <= '0;
        end else if (run) begin
            slot_q <= wrap ? '0 : slot_q + SW'(1);
        end
    end
endmodule

// File: rtl/dts_exp_mem.sv
// Expected-response table, one word per (pass, vector) pair.
module dts_exp_mem #(
    parameter int W  = 8,
    parameter int AW = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dts_fail_log.sv
// Strobe comparison, mismatch counter and first-failure capture.
module dts_fail_log #(
    parameter int W   = 8,
    parameter int VW  = 3,
    parameter int KW  = 5,
    parameter int ECW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           strobe,
    input  logic [W-1:0]   resp,
    input  logic [W-1:0]   expv,
    input  logic [VW-1:0]  vec,
    input  logic [KW-1:0]  kcur,
    output logic           mis,
    output logic           fail,
    output logic [VW-1:0]  fail_vec,
    output logic [KW-1:0]  fail_k,
    output logic [ECW-1:0] err_cnt
);
    assign mis = strobe && (resp != expv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail     <= 1'b0;
            fail_vec <= '0;
            fail_k   <= '0;
            err_cnt  <= '0;
        end else if (clr) begin
            fail     <= 1'b0;
            fail_vec <= '0;
            fail_k   <= '0;
            err_cnt  <= '0;
        end else if (mis) begin
            if (err_cnt != '1) err_cnt <= err_cnt + ECW'(1);
            if (!fail) begin
                fail     <= 1'b1;
                fail_vec <= vec;
                fail_k   <= kcur;
            end
        end
    end
endmodule

// File: rtl/dts_sequencer.sv
module dts_sequencer
    import dts_pkg::*;
#(
    parameter int W    = 8,
    parameter int NVEC = 8,
    parameter int KMAX = 16,
    parameter int ECW  = 8,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int SW  = $clog2(KMAX),
    localparam int KW  = SW + 1,
    localparam int AW  = SW + VW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [SW-1:0]  n_sel,
    input  logic           exp_we,
    input  logic [AW-1:0]  exp_addr,
    input  logic [W-1:0]   exp_wdata,
    input  logic [W-1:0]   dut_resp,
    output logic           test_clk,
    output logic           rated_en,
    output logic           vec_adv,
    output logic           strobe,
    output logic [VW-1:0]  vec_idx,
    output logic [KW-1:0]  pass_k,
    output logic           mis_hit,
    output logic           busy,
    output logic           done,
    output logic           fail,
    output logic [VW-1:0]  fail_vec,
    output logic [KW-1:0]  fail_k,
    output logic [ECW-1:0] err_cnt
);
    seq_state_t    st_q, st_d;
    logic [KW-1:0] n_q;
    logic [VW-1:0] vec_q;
    logic [KW-1:0] k_q;
    logic [SW-1:0] slot;
    logic          wrap;
    logic          run;
    logic          go;
    logic          last_vec;
    logic          last_pass;
    logic [SW-1:0] k_low;
    logic [W-1:0]  exp_word;

    assign run       = (st_q == S_RUN);
    assign go        = (st_q == S_IDLE) && start;
    assign last_vec  = (vec_q == VW'(NVEC - 1));
    assign last_pass = (k_q == n_q);
    assign k_low     = SW'(k_q - KW'(1));

    dts_phase_gen #(.SW(SW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .run   (run),
        .n_len (n_q),
        .slot  (slot),
        .wrap  (wrap),
        .tclk  (test_clk)
    );

    dts_exp_mem #(.W(W), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (exp_we),
        .waddr (exp_addr),
        .wdata (exp_wdata),
        .raddr ({k_low, vec_q}),
        .rdata (exp_word)
    );

    dts_fail_log #(.W(W), .VW(VW), .KW(KW), .ECW(ECW)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (go),
        .strobe   (strobe),
        .resp     (dut_resp),
        .expv     (exp_word),
        .vec      (vec_q),
        .kcur     (k_q),
        .mis      (mis_hit),
        .fail     (fail),
        .fail_vec (fail_vec),
        .fail_k   (fail_k),
        .err_cnt  (err_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start) st_d = S_RUN;
            S_RUN:  if (wrap && last_vec && last_pass) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // run counters: factor, vector index, pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q   <= KW'(1);
            vec_q <= '0;
            k_q   <= '0;
        end else if (go) begin
            n_q   <= {1'b0, n_sel} + KW'(1);
            vec_q <= '0;
            k_q   <= KW'(1);
        end else if (run && wrap) begin
            if (last_vec) begin
                vec_q <= '0;
                if (!last_pass) k_q <= k_q + KW'(1);
            end else begin
                vec_q <= vec_q + VW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = run;
        rated_en = run;
        done     = (st_q == S_DONE);
        vec_adv  = run && (slot == '0);
        strobe   = run && ({1'b0, slot} == k_q - KW'(1));
        vec_idx  = vec_q;
        pass_k   = k_q;
    end
endmodule

// File: rtl/dts_sequencer_chk.sv
module dts_sequencer_chk #(
    parameter int VW  = 3,
    parameter int KW  = 5,
    parameter int ECW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           strobe,
    input logic           mis_hit,
    input logic           fail,
    input logic [VW-1:0]  fail_vec,
    input logic [KW-1:0]  fail_k,
    input logic [KW-1:0]  pass_k,
    input logic [ECW-1:0] err_cnt
);
    // R12
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R11
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(fail)) |-> fail);

    // R11
    first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(fail)) |-> ($stable(fail_vec) && $stable(fail_k)));

    // R13
    pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (pass_k >= $past(pass_k)));

    // R10
    err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (err_cnt >= $past(err_cnt)));

    // R9
    mis_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis_hit |-> strobe);

    // R6
    strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);
endmodule

bind dts_sequencer dts_sequencer_chk #(.VW(VW), .KW(KW), .ECW(ECW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe),
    .mis_hit  (mis_hit),
    .fail     (fail),
    .fail_vec (fail_vec),
    .fail_k   (fail_k),
    .pass_k   (pass_k),
    .err_cnt  (err_cnt)
);

// File: tb/dts_sequencer_test.sv
`timescale 1ns/1ps
module dts_sequencer_test;
    localparam int W = 8, NVEC = 8, VW = 3, SW = 4, KW = 5, AW = 7, ECW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SW-1:0] n_sel = '0;
    logic exp_we = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    logic [W-1:0] exp_wdata = '0;
    logic [W-1:0] dut_resp;
    logic test_clk, rated_en, vec_adv, strobe, mis_hit, busy, done, fail;
    logic [VW-1:0] vec_idx, fail_vec;
    logic [KW-1:0] pass_k, fail_k;
    logic [ECW-1:0] err_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int gap = 0;
    int fv0 = -1, fk0 = -1, fv1 = -1, fk1 = -1;

    typedef struct packed {
        logic [VW-1:0] v;
        logic [KW-1:0] k;
        logic          bad;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    dts_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_sel(n_sel),
        .exp_we(exp_we), .exp_addr(exp_addr), .exp_wdata(exp_wdata),
        .dut_resp(dut_resp), .test_clk(test_clk), .rated_en(rated_en),
        .vec_adv(vec_adv), .strobe(strobe), .vec_idx(vec_idx), .pass_k(pass_k),
        .mis_hit(mis_hit), .busy(busy), .done(done), .fail(fail),
        .fail_vec(fail_vec), .fail_k(fail_k), .err_cnt(err_cnt)
    );

    function automatic logic [W-1:0] pat(input int v, input int k);
        logic [3:0] kk;
        logic [2:0] vv;
        kk = 4'(k - 1);
        vv = 3'(v);
        return 8'h3C ^ {kk, 1'b1, vv};
    endfunction

    function automatic logic is_fault(input int v, input int k);
        return (v == fv0 && k == fk0) || (v == fv1 && k == fk1);
    endfunction

    // device model: response follows applied vector and pass
    always @* dut_resp = pat(int'(vec_idx), int'(pass_k)) ^
                         (is_fault(int'(vec_idx), int'(pass_k)) ? 8'h10 : 8'h00);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops one scoreboard item per strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (vec_adv) gap = 0;
            else gap++;
            if (strobe) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 extra strobe", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(vec_idx == it.v, "R4 vector at strobe", int'(vec_idx), int'(it.v));
                    chk(pass_k == it.k, "R7 pass at strobe", int'(pass_k), int'(it.k));
                    chk(gap == int'(it.k) - 1, "R6 strobe offset", gap, int'(it.k) - 1);
                    chk(mis_hit == it.bad, "R9 mismatch flag", int'(mis_hit), int'(it.bad));
                end
            end
        end
    end

    task automatic run_case(input int n, input int a_v, input int a_k,
                            input int b_v, input int b_k, input int mid);
        int nbusy = 0, nrated = 0, ntclk = 0, nadv = 0, cyc = 0;
        int exp_err = 0, first_v = 0, first_k = 0;
        logic any = 1'b0;
        fv0 = a_v; fk0 = a_k; fv1 = b_v; fk1 = b_k;
        for (int k = 1; k <= n; k++) begin
            for (int v = 0; v < NVEC; v++) begin
                item_t it;
                it.v = VW'(v); it.k = KW'(k); it.bad = is_fault(v, k);
                sb_q.push_back(it);
                if (it.bad) begin
                    exp_err++;
                    if (!any) begin any = 1'b1; first_v = v; first_k = k; end
                end
            end
        end
        @(negedge clk);
        n_sel = SW'(n - 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 100000) begin
            if (busy) nbusy++;
            if (rated_en) nrated++;
            if (test_clk) ntclk++;
            if (vec_adv) nadv++;
            if (cyc == mid) begin start = 1'b1; n_sel = SW'(n % 16); end  // R13 stray start
            else start = 1'b0;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(done, "R12 done reached", int'(done), 1);
        chk(!busy, "R12 busy low at done", int'(busy), 0);
        chk(nbusy == n * n * NVEC, "R3 R13 run length", nbusy, n * n * NVEC);
        chk(nrated == n * n * NVEC, "R3 rated enables", nrated, n * n * NVEC);
        chk(ntclk == n * NVEC * ((n + 1) / 2), "R5 test clock high", ntclk, n * NVEC * ((n + 1) / 2));
        chk(nadv == n * NVEC, "R4 vector advances", nadv, n * NVEC);
        chk(sb_q.size() == 0, "R6 R7 strobes missing", sb_q.size(), 0);
        chk(err_cnt == ECW'(exp_err), "R10 error count", int'(err_cnt), exp_err);
        chk(fail == any, "R11 fail flag", int'(fail), int'(any));
        if (any) begin
            chk(fail_vec == VW'(first_v), "R11 first vector", int'(fail_vec), first_v);
            chk(fail_k == KW'(first_k), "R11 first pass", int'(fail_k), first_k);
        end
        sb_q.delete();
        @(negedge clk);
        chk(!done, "R12 done one cycle", int'(done), 0);
        chk(err_cnt == ECW'(exp_err), "R2 result held in idle", int'(err_cnt), exp_err);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail && !strobe && !vec_adv, "R1 idle flags", 1, 0);
        chk(!rated_en && !test_clk && !mis_hit, "R1 clocks idle", 1, 0);
        chk(err_cnt == 0, "R1 error count", int'(err_cnt), 0);
        // R8 load expected table: address {k-1, vector}
        for (int a = 0; a < (1 << AW); a++) begin
            exp_we = 1'b1;
            exp_addr = AW'(a);
            exp_wdata = pat(a % NVEC, a / NVEC + 1);
            @(negedge clk);
        end
        exp_we = 1'b0;
        // R2 R3 clean run, N = 4
        run_case(4, -1, -1, -1, -1, -1);
        // R6 N = 1: strobe shares every vec_adv cycle
        run_case(1, -1, -1, -1, -1, -1);
        // R9 R10 R11 two faults, N = 3
        run_case(3, 2, 3, 5, 2, -1);
        // R13 stray start mid-run, N = 2, with a fault
        run_case(2, 6, 1, -1, -1, 10);
        // R12 fault on the final strobe, N = 16
        run_case(16, 7, 16, -1, -1, -1);
        // R2 restart clears results
        run_case(2, -1, -1, -1, -1, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule